// File: doc/BRIEF.md
# I/O Processor Request and Mailbox Controller

This block is the control front end of an I/O processor that serves as a slave to the CPU. The CPU sends it one of three requests on a small request port: probe the I/O path, launch an I/O program at a given memory address, or report the result of the last program. The block never answers through a readable register. Every reply is a status word that it writes into a fixed memory location, the mailbox, through a memory request/grant port. The CPU later reads that word from memory.

A launch request passes the command-program address to a separate command-execution engine and sends it a start pulse. The engine then runs with no further help from the CPU. When the engine signals that it has finished, the block records whether the program completed and whether it ended in error. It then raises an interrupt. The CPU normally answers the interrupt with a report request, which clears the interrupt and makes the block write the final status to the mailbox. A launch that arrives while a program is still running is refused and flagged in the next status word.

Top module: `iop_handshake`

## Requirements
- R1: After reset, `irq`, `mbxReq` and `engStart` are low and `reqReady` is high.
- R2: An accepted probe request (`reqOp`=1) raises `mbxReq` on the following cycle with `mbxAddr` equal to the mailbox parameter. `mbxReq` stays high until the cycle in which `mbxGnt` is high. While `mbxReq` is high, `reqReady` is low and any request is ignored.
- R3: The mailbox word has these fields. Bit 0 is ready, equal to `devReady` while no program is running. Bit 1 is busy, meaning a program is running. Bit 2 is overload. Bit 3 is complete. Bit 4 is error. All higher bits are zero. The word reflects the state at the cycle the request is accepted.
- R4: An accepted launch request (`reqOp`=2) while idle gives a one-cycle `engStart` pulse on the following cycle, with `engAddr` equal to `reqAddr`. It also sets busy and clears complete and error.
- R5: A launch request while busy produces no `engStart` and leaves `engAddr` unchanged. It sets overload in the next mailbox word. Overload is cleared once that word has been captured.
- R6: `engDone` while busy clears busy, sets complete, copies `engError` into error, and raises `irq` on the next cycle. `engDone` while idle has no effect.
- R7: `irq` stays high until an accepted report request or an `irqAck` pulse, and goes low on the next cycle.
- R8: An accepted report request (`reqOp`=3) writes the status word to the mailbox in the same way as a probe.
- R9: `reqOp`=0 is a no-op and causes neither a mailbox write nor a start.
- R10: While `mbxReq` is high and `mbxGnt` is low, `mbxData` and `mbxAddr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request valid |
| reqOp | input | 2 | Request opcode: 0 none, 1 probe, 2 launch, 3 report |
| reqAddr | input | AW | Command-program address for launch |
| reqReady | output | 1 | Request can be accepted this cycle |
| devReady | input | 1 | Attached device can take a transfer |
| mbxReq | output | 1 | Mailbox write request |
| mbxAddr | output | AW | Mailbox address |
| mbxData | output | DW | Status word to write |
| mbxGnt | input | 1 | Memory grant, completes the write |
| engStart | output | 1 | One-cycle start to the execution engine |
| engAddr | output | AW | Command-program address for the engine |
| engDone | input | 1 | Engine finished the program |
| engError | input | 1 | Program ended in error, valid with engDone |
| irq | output | 1 | Interrupt request to the CPU |
| irqAck | input | 1 | Interrupt acknowledge |

## Verification
A stuck or wrongly set busy flag shows up in two places: the busy and ready bits of the very next mailbox word, and whether the next launch gives an `engStart` one cycle after acceptance. A lost overload, complete or error flag shows up as a wrong bit in the first mailbox word captured after the event. A faulty interrupt latch shows on `irq` one cycle after `engDone`, `irqAck` or a report. A broken mailbox handshake shows within a cycle as `mbxReq` dropping before the grant, a data word changing while waiting, or `reqReady` staying high during a pending write.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROBE = 2'd1,
    OP_LAUNCH = 2'd2,
    OP_REPORT = 2'd3
  } reqOpT;

  localparam int ST_READY    = 0;
  localparam int ST_BUSY     = 1;
  localparam int ST_OVERLOAD = 2;
  localparam int ST_COMPLETE = 3;
  localparam int ST_ERROR    = 4;
  localparam int ST_BITS     = 5;

  typedef struct packed {
    logic snapStatus;
    logic loadAddr;
    logic setOverload;
    logic latchResult;
  } strobeT;
endpackage

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       mbxGnt,
  input  logic       engDone,
  input  logic       irqAck,
  output logic       reqReady,
  output logic       mbxReq,
  output logic       engStart,
  output logic       running,
  output logic       irq,
  output strobeT     strb
);
  logic accept;
  logic isProbe, isLaunch, isReport;

  assign reqReady = !mbxReq;
  assign accept   = reqValid && reqReady;
  assign isProbe  = accept && (reqOp == OP_PROBE);
  assign isLaunch = accept && (reqOp == OP_LAUNCH);
  assign isReport = accept && (reqOp == OP_REPORT);

  always_comb begin
    strb.snapStatus  = isProbe || isReport;
    strb.loadAddr    = isLaunch && !running;
    strb.setOverload = isLaunch && running;
    strb.latchResult = engDone && running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mbxReq   <= 1'b0;
      engStart <= 1'b0;
      running  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      engStart <= strb.loadAddr;

      if (strb.snapStatus)  mbxReq <= 1'b1;
      else if (mbxGnt)      mbxReq <= 1'b0;

      if (strb.loadAddr)         running <= 1'b1;
      else if (strb.latchResult) running <= 1'b0;

      if (strb.latchResult)          irq <= 1'b1;
      else if (isReport || irqAck)   irq <= 1'b0;
    end
  end
endmodule

// File: rtl/iop_dpath.sv
module iop_dpath
  import iop_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic          running,
  input  logic          devReady,
  input  logic          engError,
  input  logic [AW-1:0] reqAddr,
  output logic [DW-1:0] statusQ,
  output logic [AW-1:0] engAddrQ
);
  logic overload, complete, errFlag;
  logic [DW-1:0] snapshot;

  always_comb begin
    snapshot = '0;
    snapshot[ST_READY]    = devReady && !running;
    snapshot[ST_BUSY]     = running;
    snapshot[ST_OVERLOAD] = overload;
    snapshot[ST_COMPLETE] = complete;
    snapshot[ST_ERROR]    = errFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overload <= 1'b0;
      complete <= 1'b0;
      errFlag  <= 1'b0;
      statusQ  <= '0;
      engAddrQ <= '0;
    end else begin
      if (strb.setOverload)     overload <= 1'b1;
      else if (strb.snapStatus) overload <= 1'b0;

      if (strb.loadAddr) begin
        complete <= 1'b0;
        errFlag  <= 1'b0;
        engAddrQ <= reqAddr;
      end else if (strb.latchResult) begin
        complete <= 1'b1;
        errFlag  <= engError;
      end

      if (strb.snapStatus) statusQ <= snapshot;
    end
  end
endmodule

// File: rtl/iop_handshake.sv
module iop_handshake
  import iop_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 32,
  parameter logic [AW-1:0] MBX_ADDR = 16'h0F00
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  input  logic          devReady,
  output logic          mbxReq,
  output logic [AW-1:0] mbxAddr,
  output logic [DW-1:0] mbxData,
  input  logic          mbxGnt,
  output logic          engStart,
  output logic [AW-1:0] engAddr,
  input  logic          engDone,
  input  logic          engError,
  output logic          irq,
  input  logic          irqAck
);
  strobeT strb;
  logic   running;

  iop_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .mbxGnt(mbxGnt), .engDone(engDone), .irqAck(irqAck),
    .reqReady(reqReady), .mbxReq(mbxReq), .engStart(engStart),
    .running(running), .irq(irq), .strb(strb)
  );

  iop_dpath #(.AW(AW), .DW(DW)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .running(running),
    .devReady(devReady), .engError(engError), .reqAddr(reqAddr),
    .statusQ(mbxData), .engAddrQ(engAddr)
  );

  assign mbxAddr = MBX_ADDR;
endmodule

// File: rtl/iop_handshake_chk.sv
module iop_handshake_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [1:0]    reqOp,
  input logic          reqReady,
  input logic          mbxReq,
  input logic [AW-1:0] mbxAddr,
  input logic [DW-1:0] mbxData,
  input logic          mbxGnt,
  input logic          engStart,
  input logic          irq,
  input logic          irqAck
);
  a_r2_no_req_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    mbxReq |-> !reqReady);

  a_r2_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    (mbxReq && !mbxGnt) |=> mbxReq);

  a_r10_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (mbxReq && !mbxGnt) |=> ($stable(mbxData) && $stable(mbxAddr)));

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    mbxReq |-> (mbxData[DW-1:5] == '0));

  a_r8_write_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mbxReq) |-> $past(reqValid && reqReady && reqOp[0]));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  a_r7_irq_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqAck || (reqValid && reqReady && reqOp == 2'd3)));
endmodule

bind iop_handshake iop_handshake_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .reqReady(reqReady), .mbxReq(mbxReq), .mbxAddr(mbxAddr),
  .mbxData(mbxData), .mbxGnt(mbxGnt), .engStart(engStart),
  .irq(irq), .irqAck(irqAck)
);

// File: tb/iop_handshake_tb.sv
module iop_handshake_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] MBX = 16'h0F00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic reqReady, devReady = 1'b0;
  logic mbxReq, mbxGnt = 1'b0;
  logic [AW-1:0] mbxAddr, engAddr;
  logic [DW-1:0] mbxData;
  logic engStart, engDone = 1'b0, engError = 1'b0, irq, irqAck = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] lastAddr = '0;

  always #10 clk = ~clk;

  iop_handshake #(.AW(AW), .DW(DW), .MBX_ADDR(MBX)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqReady(reqReady), .devReady(devReady),
    .mbxReq(mbxReq), .mbxAddr(mbxAddr), .mbxData(mbxData), .mbxGnt(mbxGnt),
    .engStart(engStart), .engAddr(engAddr), .engDone(engDone),
    .engError(engError), .irq(irq), .irqAck(irqAck)
  );

  typedef struct packed {
    logic          isDone;
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic          flag;
    logic [4:0]    exp;
  } stepT;

  localparam int NSTEP = 12;
  localparam stepT STEPS [NSTEP] = '{
    '{1'b0, 2'd1, 16'h0000, 1'b1, 5'b00001},
    '{1'b0, 2'd1, 16'h0000, 1'b0, 5'b00000},
    '{1'b0, 2'd2, 16'h1234, 1'b1, 5'b00001},
    '{1'b0, 2'd1, 16'h0000, 1'b1, 5'b00010},
    '{1'b0, 2'd2, 16'h5555, 1'b1, 5'b00000},
    '{1'b0, 2'd1, 16'h0000, 1'b1, 5'b00110},
    '{1'b0, 2'd1, 16'h0000, 1'b1, 5'b00010},
    '{1'b1, 2'd0, 16'h0000, 1'b0, 5'b00000},
    '{1'b0, 2'd3, 16'h0000, 1'b1, 5'b01001},
    '{1'b0, 2'd2, 16'h00AB, 1'b1, 5'b00001},
    '{1'b1, 2'd0, 16'h0000, 1'b1, 5'b00000},
    '{1'b0, 2'd3, 16'h0000, 1'b0, 5'b11000}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendReq(input logic [1:0] op, input logic [AW-1:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0; reqOp = 2'd0;
  endtask

  // Called at the negedge right after acceptance: checks the word, waits, grants.
  task automatic drainMbx(input logic [4:0] exp, input string req);
    logic [DW-1:0] first;
    check(mbxReq === 1'b1, "R2 mbxReq raised", mbxReq, 1);
    check(mbxAddr === MBX, "R2 mailbox address", mbxAddr, MBX);
    check(mbxData === {{(DW-5){1'b0}}, exp}, req, mbxData, exp);
    check(reqReady === 1'b0, "R2 reqReady low while pending", reqReady, 0);
    first = mbxData;
    @(negedge clk);
    check(mbxReq === 1'b1 && mbxData === first, "R10 held until grant", mbxData, first);
    mbxGnt = 1'b1;
    @(negedge clk);
    mbxGnt = 1'b0;
    check(mbxReq === 1'b0, "R2 released after grant", mbxReq, 0);
  endtask

  task automatic pulseDone(input logic err);
    @(negedge clk);
    engDone = 1'b1; engError = err;
    @(negedge clk);
    engDone = 1'b0; engError = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq === 0 && mbxReq === 0 && engStart === 0 && reqReady === 1,
          "R1 reset state", {irq, mbxReq, engStart, reqReady}, 4'b0001);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      stepT s = STEPS[i];
      if (s.isDone) begin
        pulseDone(s.flag);
        check(irq === 1'b1, "R6 irq after done", irq, 1);
      end else begin
        devReady = s.flag;
        sendReq(s.op, s.addr);
        if (s.op == 2'd2) begin
          if (s.exp[0]) begin
            check(engStart === 1'b1, "R4 start pulse", engStart, 1);
            check(engAddr === s.addr, "R4 program address", engAddr, s.addr);
            lastAddr = s.addr;
            @(negedge clk);
            check(engStart === 1'b0, "R4 pulse one cycle", engStart, 0);
          end else begin
            check(engStart === 1'b0, "R5 refused launch", engStart, 0);
            check(engAddr === lastAddr, "R5 address kept", engAddr, lastAddr);
          end
        end else begin
          if (s.op == 2'd3) check(irq === 1'b0, "R7 report clears irq", irq, 0);
          drainMbx(s.exp, s.op == 2'd3 ? "R8 report word (R3 layout)" : "R3 probe word");
        end
      end
    end

    // R9: no-op opcode
    sendReq(2'd0, 16'h7777);
    check(mbxReq === 1'b0 && engStart === 1'b0, "R9 no-op ignored", {mbxReq, engStart}, 0);

    // R7: acknowledge clears irq
    devReady = 1'b1;
    sendReq(2'd2, 16'h0042);
    lastAddr = 16'h0042;
    pulseDone(1'b0);
    check(irq === 1'b1, "R6 irq raised", irq, 1);
    @(negedge clk);
    check(irq === 1'b1, "R7 irq held", irq, 1);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    check(irq === 1'b0, "R7 ack clears irq", irq, 0);

    // R6: done while idle has no effect
    pulseDone(1'b1);
    check(irq === 1'b0, "R6 idle done ignored irq", irq, 0);
    sendReq(2'd1, '0);
    drainMbx(5'b01001, "R6 idle done leaves error clear");

    // R2: launch during pending write is ignored
    sendReq(2'd1, '0);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd2; reqAddr = 16'h0BAD;
    @(negedge clk);
    reqValid = 1'b0; reqOp = 2'd0;
    check(engStart === 1'b0 && engAddr === lastAddr, "R2 request ignored while pending", engAddr, lastAddr);
    mbxGnt = 1'b1;
    @(negedge clk);
    mbxGnt = 1'b0;
    sendReq(2'd1, '0);
    drainMbx(5'b01001, "R2 ignored launch left block idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule